// File: doc/BRIEF.md
# MDIO Management Command Controller

This block turns a single packed command word into a complete management frame on the two-wire PHY management bus (MDC clock, MDIO data). Software writes the command word, which names the PHY, the PHY register, the data to write and the operation. While the frame is on the wire the block holds a busy bit in its status word. When a read finishes, the returned 16 bits and two error bits appear in the data word. Software polls the busy bit before it issues the next command.

MDC is produced only while a frame is in flight. Its period is `CLK_DIV` system clocks, which must be an even number of at least 2. The block changes MDIO only on the falling edge of MDC, and during a read it samples MDIO on the rising edge. The command port is a plain write strobe with no back-pressure. A command that arrives while the block is busy, or that is not valid, is dropped and is never queued.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: A command is accepted only when the write strobe is high, bit 31 of the command word is set and the opcode in bits 2:1 is 1 (write) or 2 (read). Opcodes 0 and 3, or a word with bit 31 clear, start nothing. The command word holds the PHY address in bits 29:25, the register number in bits 24:20 and the write data in bits 19:4.
- R2: A command strobed while an operation is in progress is ignored. The frame in flight is not altered and no second frame follows it.
- R3: Status bit 3 is high from the cycle after a command is accepted until the frame ends. All other status bits read zero.
- R4: While busy, MDC has a period of `CLK_DIV` system clocks. MDIO changes only while MDC is low. MDC stays low while idle.
- R5: A write frame carries, MSB first: 32 ones, start bits 01, opcode bits 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and 16 data bits. MDIO is driven for all 64 bits.
- R6: A read frame carries the same first 46 bits with opcode bits 10. The block stops driving MDIO from the first turnaround bit (bit 46) to the end of the frame.
- R7: In a read, the 16 bits that the PHY presents after turnaround are captured MSB first on rising MDC and appear in data bits 15:0 when busy clears.
- R8: If the PHY does not present a zero in the second turnaround bit of a read, data bits 17:16 become 11. Otherwise they become 00. Data bits 31:18 are always zero.
- R9: A write operation leaves the data word unchanged.
- R10: After reset the block is idle: busy low, MDC low, MDIO not driven, data word zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_word | input | 32 | Packed command word |
| status_o | output | 32 | Status word, bit 3 is busy |
| data_o | output | 32 | Read data word with error bits |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Four properties are checked on every cycle. The bus is quiet while the block is idle. A frame starts only after a valid strobe. MDIO holds while MDC is high. The data word changes only at the end of a frame, with its error bits equal. The bench scenarios cover what those properties cannot show. They reconstruct each frame bit by bit and compare it with the expected layout. They confirm where the block releases MDIO, check returned data and turnaround errors against a responder, and show that strobes during busy, or with a bad flag or opcode, leave the bus and the registers untouched.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_FIRST  = 46;
  localparam int TA_LAST   = 47;
  localparam int DATA_LEN  = 16;

  localparam int CMD_GO_BIT  = 31;
  localparam int CMD_PHY_LSB = 25;
  localparam int CMD_REG_LSB = 20;
  localparam int CMD_WD_LSB  = 4;
  localparam int CMD_OP_LSB  = 1;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSVD = 2'd3
  } mgmt_op_e;

  function automatic logic [FRAME_LEN-1:0] make_frame(input logic [31:0] cmd);
    logic       is_rd;
    logic [1:0] op_code;
    logic [1:0] ta;
    logic [15:0] payload;
    is_rd   = (cmd[CMD_OP_LSB +: 2] == OP_RD);
    op_code = is_rd ? 2'b10 : 2'b01;
    ta      = is_rd ? 2'b11 : 2'b10;
    payload = is_rd ? 16'hFFFF : cmd[CMD_WD_LSB +: 16];
    make_frame = {32'hFFFF_FFFF, 2'b01, op_code,
                  cmd[CMD_PHY_LSB +: 5], cmd[CMD_REG_LSB +: 5], ta, payload};
  endfunction
endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign rise_stb = run && (cnt_q == CW'(HALF - 1));
  assign fall_stb = run && (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= fall_stb ? '0 : cnt_q + 1'b1;
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 load_is_rd,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_LEN-1:0]  rd_bits,
  output logic                 ta_err
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] sreg_q;
  logic [IW-1:0]        idx_q;
  logic                 active_q;
  logic                 rd_q;
  logic                 in_data;

  assign in_data = (idx_q >= IW'(TA_LAST + 1));
  assign done    = active_q && fall_stb && (idx_q == IW'(FRAME_LEN - 1));
  assign mdio_oe = active_q && !(rd_q && (idx_q >= IW'(TA_FIRST)));
  assign mdio_o  = mdio_oe ? sreg_q[FRAME_LEN-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      rd_bits  <= '0;
      ta_err   <= 1'b0;
    end else if (load) begin
      sreg_q   <= frame_in;
      idx_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= load_is_rd;
      ta_err   <= 1'b0;
    end else if (active_q) begin
      if (rise_stb && rd_q) begin
        if (idx_q == IW'(TA_LAST)) ta_err  <= mdio_i;
        if (in_data)               rd_bits <= {rd_bits[DATA_LEN-2:0], mdio_i};
      end
      if (fall_stb) begin
        sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b1};
        idx_q  <= idx_q + 1'b1;
        if (done) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_word,
  output logic [31:0] status_o,
  output logic [31:0] data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic       busy_q;
  logic       op_rd_q;
  logic       accept;
  logic       rise_stb, fall_stb, done, ta_err;
  logic [DATA_LEN-1:0] rd_bits;
  mgmt_op_e   op;

  assign op     = mgmt_op_e'(cmd_word[CMD_OP_LSB +: 2]);
  assign accept = cmd_we && cmd_word[CMD_GO_BIT] && !busy_q &&
                  (op == OP_WR || op == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      data_o  <= '0;
    end else begin
      if (accept) begin
        busy_q  <= 1'b1;
        op_rd_q <= (op == OP_RD);
      end else if (done) begin
        busy_q <= 1'b0;
        if (op_rd_q) data_o <= {14'b0, {2{ta_err}}, rd_bits};
      end
    end
  end

  assign status_o = {28'b0, busy_q, 3'b0};

  mdc_clock_gen #(.CLK_DIV(CLK_DIV)) clk_gen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .mdc      (mdc_o),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_shifter shift_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .frame_in   (make_frame(cmd_word)),
    .load_is_rd (op == OP_RD),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done       (done),
    .rd_bits    (rd_bits),
    .ta_err     (ta_err)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [31:0] cmd_word,
  input logic        busy,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] data_o
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc_o));

  a_r1_start_needs_valid_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we && cmd_word[31] &&
                          (cmd_word[2:1] == 2'd1 || cmd_word[2:1] == 2'd2)));

  a_r4_mdio_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc_o && $past(mdc_o)) |-> $stable(mdio_o));

  a_r9_data_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(data_o));

  a_r8_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (data_o[17] == data_o[16]) && (data_o[31:18] == 14'b0));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_we   (cmd_we),
  .cmd_word (cmd_word),
  .busy     (busy_q),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .data_o   (data_o)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] status_o, data_o;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int mon_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wd;
    logic [15:0] resp;
    logic        ta_ok;
  } txn_t;
  txn_t exp_q[$];
  logic [31:0] last_data = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .status_o(status_o), .data_o(data_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic go, input logic [1:0] op,
                                       input logic [4:0] phy, input logic [4:0] rg,
                                       input logic [15:0] wd);
    return {go, 1'b0, phy, rg, wd, 1'b0, op, 1'b0};
  endfunction

  task automatic strobe(input logic [31:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_we   = 1'b1;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  // driver: pushes expectation then issues command
  task automatic run_txn(input txn_t t, input bit intrude);
    int target;
    exp_q.push_back(t);
    target = mon_cnt + 1;
    strobe(pack(1'b1, t.rd ? 2'd2 : 2'd1, t.phy, t.regn, t.wd));
    if (intrude) begin
      repeat (30) @(negedge clk);
      strobe(pack(1'b1, 2'd1, ~t.phy, ~t.regn, 16'hDEAD)); // R2 ignored while busy
    end
    wait (mon_cnt == target);
  endtask

  task automatic expect_idle(input string req, input int cyc);
    logic seen;
    seen = 1'b0;
    repeat (cyc) begin
      @(negedge clk);
      if (status_o[3] || mdc_o || mdio_oe) seen = 1'b1;
    end
    check(req, {63'b0, seen}, 64'd0);
  endtask

  // monitor + PHY responder
  initial begin
    forever begin
      txn_t t;
      logic [63:0] got, exp, oe_got, oe_exp, mask;
      realtime t0, t1;
      wait (status_o[3] === 1'b1);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 got=unexpected frame exp=none");
        wait (status_o[3] === 1'b0);
        continue;
      end
      t = exp_q.pop_front();
      got = '0; oe_got = '0;
      for (int i = 0; i < 64; i++) begin
        if (t.rd && i == 46)      mdio_i = 1'b1;
        else if (t.rd && i == 47) mdio_i = t.ta_ok ? 1'b0 : 1'b1;
        else if (t.rd && i >= 48) mdio_i = t.resp[63 - i];
        else                      mdio_i = 1'b1;
        @(posedge mdc_o);
        if (i == 0) t0 = $realtime;
        if (i == 1) t1 = $realtime;
        #1;
        got[63 - i]    = mdio_o;
        oe_got[63 - i] = mdio_oe;
      end
      mdio_i = 1'b1;
      exp = {32'hFFFF_FFFF, 2'b01, t.rd ? 2'b10 : 2'b01, t.phy, t.regn, 2'b10, t.wd};
      mask   = t.rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
      oe_exp = mask;
      check(t.rd ? "R6 frame" : "R5 frame", got & mask, exp & mask);
      check(t.rd ? "R6 release" : "R5 driven", oe_got, oe_exp);
      check("R4 period", 64'(int'((t1 - t0) * 10.0)), 64'(DIV * 50));
      check("R3 busy during frame", {63'b0, status_o[3]}, 64'd1);
      wait (status_o[3] === 1'b0);
      @(negedge clk);
      if (t.rd) begin
        last_data = {14'b0, t.ta_ok ? 2'b00 : 2'b11, t.resp};
        check(t.ta_ok ? "R7 read data" : "R8 ta error", {32'b0, data_o}, {32'b0, last_data});
      end else begin
        check("R9 write keeps data", {32'b0, data_o}, {32'b0, last_data});
      end
      check("R3 other status bits", {32'b0, status_o}, 64'd0);
      mon_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    txn_t t;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {28'b0, status_o[3], mdc_o, mdio_oe, 1'b0, data_o},
          {28'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'b0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    t = '{rd:1'b0, phy:5'h13, regn:5'h0A, wd:16'hA5C3, resp:16'h0, ta_ok:1'b1};
    run_txn(t, 0);
    t = '{rd:1'b1, phy:5'h01, regn:5'h1F, wd:16'h0, resp:16'h8421, ta_ok:1'b1};
    run_txn(t, 0);
    t = '{rd:1'b0, phy:5'h1F, regn:5'h00, wd:16'hFFFF, resp:16'h0, ta_ok:1'b1};
    run_txn(t, 0);
    t = '{rd:1'b1, phy:5'h05, regn:5'h12, wd:16'h0, resp:16'h3C5A, ta_ok:1'b0};
    run_txn(t, 0);
    t = '{rd:1'b1, phy:5'h0A, regn:5'h04, wd:16'h0, resp:16'hF00F, ta_ok:1'b1};
    run_txn(t, 1);
    expect_idle("R2 no queued command", 40);

    strobe(pack(1'b0, 2'd1, 5'h3, 5'h3, 16'h1234));
    expect_idle("R1 go bit clear", 20);
    strobe(pack(1'b1, 2'd0, 5'h3, 5'h3, 16'h1234));
    expect_idle("R1 opcode 0", 20);
    strobe(pack(1'b1, 2'd3, 5'h3, 5'h3, 16'h1234));
    expect_idle("R1 opcode 3", 20);
    check("R1 data untouched", {32'b0, data_o}, {32'b0, last_data});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule